// File: doc/BRIEF.md
# Linked-Load / Store-Conditional Reservation Table

This block keeps the open atomic reservations on the memory side of a shared store. Each reservation pairs a target address with an authentication key. A linked load either returns the key already on record for that address, or takes a fresh key from a wrapping counter and records the pair. A later store-conditional must present both the address and the key. It succeeds only while that exact pair is still on record.

A successful store-conditional removes its reservation and raises a write enable for the data store. A failed one leaves every entry as it was. Because success consumes the reservation, the first store-conditional to reach the block wins any race. Every key has a bounded life: when a new key is issued, any entry holding the key exactly half the key space away is dropped. When no slot is free, a round-robin pointer picks the slot to overwrite.

Requests arrive one per cycle on a request channel. Each request is answered exactly one cycle later on a registered response channel.

Top module: `resv_table`

## Requirements
- R1: After a synchronous reset, no entry is valid, `rsp_valid` is low and the key counter is zero, so the first new reservation returns key 1.
- R2: A linked load (`req_op` = 0) to an address that holds a valid reservation returns that reservation's key and allocates no key, so the next new reservation still gets the next counter value.
- R3: A linked load to an address with no valid reservation returns the counter plus one, modulo 2^KEY_W, stores that key with the address, and the counter advances by exactly one.
- R4: A store-conditional (`req_op` = 1) whose address and key both match a valid entry returns `rsp_ok` = 1 and `rsp_wen` = 1, and clears that entry. A second store-conditional with the same pair therefore fails, so the first to arrive wins.
- R5: A store-conditional with no matching valid entry returns `rsp_ok` = 0 and `rsp_wen` = 0 and leaves the table unchanged, including the reservation a wrong key was aimed at.
- R6: When a new key K' is issued, every valid entry whose key K satisfies K' − K = 2^(KEY_W−1) modulo 2^KEY_W is invalidated in the same cycle.
- R7: A new reservation takes the lowest-indexed free slot. When all slots are valid, it takes the slot named by a round-robin pointer. The pointer starts at 0 and advances by one only on such a replacement.
- R8: Each accepted request yields `rsp_valid` high for exactly one cycle, on the clock edge after the request. With no request, `rsp_valid` stays low. On a store-conditional, `rsp_key` echoes the request key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 1 | 0 = linked load, 1 = store-conditional |
| req_addr | input | ADDR_W | Target address |
| req_key | input | KEY_W | Key presented by a store-conditional |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_key | output | KEY_W | Reservation key (LL) or echoed key (SC) |
| rsp_ok | output | 1 | Store-conditional succeeded |
| rsp_wen | output | 1 | Write enable for the data store |

## Verification
Every result is due exactly one clock edge after its request: the response register, the table update and the counter step all load on that same edge. The bench drives each request on a falling edge and samples the response on the next falling edge, half a cycle after the edge that loaded it. Table effects such as consumption, expiry and eviction show up in the responses to later requests, never in the same cycle. Expiry and round-robin replacement are exercised with a small key width and a small entry count, so that both corners are reached in a few dozen cycles.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic {
        OP_LL = 1'b0,
        OP_SC = 1'b1
    } resv_op_e;

    localparam int DEF_ENTRIES = 32;
    localparam int DEF_ADDR_W  = 40;
    localparam int DEF_KEY_W   = 32;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/resv_pick.sv
module resv_pick #(
    parameter int N     = 32,
    parameter int IDX_W = resv_pkg::idx_width(N)
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/resv_match.sv
module resv_match #(
    parameter int ENTRIES = 32,
    parameter int ADDR_W  = 40,
    parameter int KEY_W   = 32
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] addr_tab,
    input  logic [ENTRIES-1:0][KEY_W-1:0]  key_tab,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [KEY_W-1:0]               req_key,
    input  logic [KEY_W-1:0]               fresh_key,
    output logic [ENTRIES-1:0]             addr_hit,
    output logic [ENTRIES-1:0]             pair_hit,
    output logic [ENTRIES-1:0]             stale
);
    localparam logic [KEY_W-1:0] HALF = {1'b1, {(KEY_W-1){1'b0}}};

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic a_eq;
        assign a_eq        = (addr_tab[g] == req_addr);
        assign addr_hit[g] = valid[g] && a_eq;
        assign pair_hit[g] = valid[g] && a_eq && (key_tab[g] == req_key);
        // distance of exactly half the key space: difference equals the MSB alone
        assign stale[g]    = valid[g] && ((fresh_key - key_tab[g]) == HALF);
    end
endmodule

// File: rtl/resv_alloc.sv
module resv_alloc #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = resv_pkg::idx_width(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] free_vec,
    input  logic               take,
    output logic [IDX_W-1:0]   slot
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    resv_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_free (
        .vec (free_vec),
        .idx (free_idx),
        .any (any_free)
    );

    assign slot = any_free ? free_idx : rr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (take && !any_free) begin
            if (rr_q == IDX_W'(ENTRIES - 1))
                rr_q <= '0;
            else
                rr_q <= rr_q + IDX_W'(1);
        end
    end
endmodule

// File: rtl/resv_table.sv
module resv_table #(
    parameter int ENTRIES = resv_pkg::DEF_ENTRIES,
    parameter int ADDR_W  = resv_pkg::DEF_ADDR_W,
    parameter int KEY_W   = resv_pkg::DEF_KEY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [KEY_W-1:0]  req_key,
    output logic              rsp_valid,
    output logic [KEY_W-1:0]  rsp_key,
    output logic              rsp_ok,
    output logic              rsp_wen
);
    import resv_pkg::*;

    localparam int IDX_W = idx_width(ENTRIES);

    logic [ENTRIES-1:0]             valid_q, valid_d;
    logic [ENTRIES-1:0][ADDR_W-1:0] addr_q;
    logic [ENTRIES-1:0][KEY_W-1:0]  key_q;
    logic [KEY_W-1:0]               ctr_q;
    logic [KEY_W-1:0]               fresh_key;

    logic [ENTRIES-1:0] addr_hit, pair_hit, stale;
    logic [IDX_W-1:0]   hit_idx, pair_idx, slot;
    logic               any_addr, any_pair;
    logic               is_ll, is_sc, need_new, sc_win;
    resv_op_e           op;

    assign op        = resv_op_e'(req_op);
    assign fresh_key = ctr_q + KEY_W'(1);

    resv_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_match (
        .valid     (valid_q),
        .addr_tab  (addr_q),
        .key_tab   (key_q),
        .req_addr  (req_addr),
        .req_key   (req_key),
        .fresh_key (fresh_key),
        .addr_hit  (addr_hit),
        .pair_hit  (pair_hit),
        .stale     (stale)
    );

    resv_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit (
        .vec (addr_hit),
        .idx (hit_idx),
        .any (any_addr)
    );

    resv_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pair (
        .vec (pair_hit),
        .idx (pair_idx),
        .any (any_pair)
    );

    assign is_ll    = req_valid && (op == OP_LL);
    assign is_sc    = req_valid && (op == OP_SC);
    assign need_new = is_ll && !any_addr;
    assign sc_win   = is_sc && any_pair;

    resv_alloc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_alloc (
        .clk      (clk),
        .rst      (rst),
        .free_vec (~valid_q | stale),
        .take     (need_new),
        .slot     (slot)
    );

    always_comb begin
        valid_d = valid_q;
        if (need_new) begin
            valid_d       = valid_q & ~stale;
            valid_d[slot] = 1'b1;
        end
        if (sc_win)
            valid_d[pair_idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= '0;
            ctr_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_key   <= '0;
            rsp_ok    <= 1'b0;
            rsp_wen   <= 1'b0;
        end else begin
            valid_q   <= valid_d;
            rsp_valid <= req_valid;
            rsp_ok    <= sc_win;
            rsp_wen   <= sc_win;
            if (need_new) begin
                ctr_q        <= fresh_key;
                addr_q[slot] <= req_addr;
                key_q[slot]  <= fresh_key;
            end
            if (is_ll)
                rsp_key <= any_addr ? key_q[hit_idx] : fresh_key;
            else
                rsp_key <= req_key;
        end
    end
endmodule

// File: rtl/resv_table_chk.sv
module resv_table_chk #(
    parameter int ENTRIES = 32,
    parameter int KEY_W   = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_op,
    input logic               rsp_valid,
    input logic               rsp_ok,
    input logic               rsp_wen,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [KEY_W-1:0]   ctr
);
    logic seen_q = 1'b0;
    always_ff @(posedge clk) seen_q <= 1'b1;

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        (seen_q && $past(rst)) |-> (valid_vec == '0 && ctr == '0));

    assert_key_step_R3: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !$past(rst)) |-> (ctr == $past(ctr) || ctr == $past(ctr) + KEY_W'(1)));

    assert_sc_consumes_R4: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !$past(rst) && rsp_valid && rsp_ok)
            |-> ($countones(valid_vec) + 1 == $countones($past(valid_vec))));

    assert_wen_needs_ok_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_wen |-> (rsp_valid && rsp_ok));

    assert_sc_fail_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !$past(rst) && rsp_valid && $past(req_op) && !rsp_ok)
            |-> (valid_vec == $past(valid_vec)));

    assert_resp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !$past(rst)) |-> (rsp_valid == $past(req_valid)));
endmodule

bind resv_table resv_table_chk #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_wen   (rsp_wen),
    .valid_vec (valid_q),
    .ctr       (ctr_q)
);

// File: tb/resv_table_tb.sv
module resv_table_tb;
    localparam int ENTRIES = 8;
    localparam int ADDR_W  = 8;
    localparam int KEY_W   = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_op = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [KEY_W-1:0]  req_key = '0;
    logic              rsp_valid, rsp_ok, rsp_wen;
    logic [KEY_W-1:0]  rsp_key;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    resv_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_op (req_op),
        .req_addr (req_addr), .req_key (req_key), .rsp_valid (rsp_valid),
        .rsp_key (rsp_key), .rsp_ok (rsp_ok), .rsp_wen (rsp_wen)
    );

    typedef struct packed {
        logic              op;
        logic [ADDR_W-1:0] addr;
        logic [KEY_W-1:0]  key;
        logic [KEY_W-1:0]  exp_key;
        logic              exp_ok;
        logic              exp_wen;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h10, 5'd0, 5'd1, 1'b0, 1'b0},  // R3 first key is 1
        '{1'b0, 8'h20, 5'd0, 5'd2, 1'b0, 1'b0},  // R3
        '{1'b0, 8'h10, 5'd0, 5'd1, 1'b0, 1'b0},  // R2 existing key
        '{1'b1, 8'h10, 5'd2, 5'd2, 1'b0, 1'b0},  // R5 wrong key
        '{1'b1, 8'h30, 5'd1, 5'd1, 1'b0, 1'b0},  // R5 wrong address
        '{1'b1, 8'h10, 5'd1, 5'd1, 1'b1, 1'b1},  // R4 win, R5 table kept
        '{1'b1, 8'h10, 5'd1, 5'd1, 1'b0, 1'b0},  // R4 second SC loses
        '{1'b0, 8'h10, 5'd0, 5'd3, 1'b0, 1'b0},  // R3 new key
        '{1'b0, 8'h20, 5'd0, 5'd2, 1'b0, 1'b0},  // R2
        '{1'b1, 8'h20, 5'd2, 5'd2, 1'b1, 1'b1},  // R4
        '{1'b1, 8'h10, 5'd3, 5'd3, 1'b1, 1'b1}   // R4
    };

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a falling edge; the response is sampled at the next falling edge
    task automatic issue(input logic op, input logic [ADDR_W-1:0] a, input logic [KEY_W-1:0] k,
                         input logic [KEY_W-1:0] ek, input logic eok, input logic ewen,
                         input string tag);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_key   = k;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, {tag, " rsp_valid"}, int'(rsp_valid), 1);
        check(rsp_key == ek,     {tag, " rsp_key"},   int'(rsp_key),   int'(ek));
        check(rsp_ok == eok,     {tag, " rsp_ok"},    int'(rsp_ok),    int'(eok));
        check(rsp_wen == ewen,   {tag, " rsp_wen"},   int'(rsp_wen),   int'(ewen));
    endtask

    task automatic do_reset();
        rst       = 1'b1;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    endtask

    initial begin
        do_reset();

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = VECS[i].op ? (VECS[i].exp_ok ? "R4" : "R5") : "R3";
            issue(VECS[i].op, VECS[i].addr, VECS[i].key, VECS[i].exp_key,
                  VECS[i].exp_ok, VECS[i].exp_wen, $sformatf("%s vec%0d", tag, i));
        end

        // R8: idle cycle gives no response
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8 idle no response", int'(rsp_valid), 0);

        // R2: hit allocates nothing, counter continues from 3
        issue(1'b0, 8'h40, 5'd0, 5'd4, 1'b0, 1'b0, "R3 new 0x40");
        issue(1'b0, 8'h40, 5'd0, 5'd4, 1'b0, 1'b0, "R2 repeat 0x40");
        issue(1'b0, 8'h50, 5'd0, 5'd5, 1'b0, 1'b0, "R2 no key consumed");

        // R1 again, then R7: fill, then round-robin replacement
        do_reset();
        for (int i = 1; i <= 8; i++)
            issue(1'b0, ADDR_W'(i), 5'd0, KEY_W'(i), 1'b0, 1'b0, "R1 R7 fill");
        issue(1'b0, 8'h09, 5'd0, 5'd9,  1'b0, 1'b0, "R7 evict slot0");
        issue(1'b0, 8'h0A, 5'd0, 5'd10, 1'b0, 1'b0, "R7 evict slot1");
        issue(1'b1, 8'h01, 5'd1, 5'd1, 1'b0, 1'b0, "R7 0x01 evicted");
        issue(1'b1, 8'h02, 5'd2, 5'd2, 1'b0, 1'b0, "R7 0x02 evicted");
        issue(1'b1, 8'h03, 5'd3, 5'd3, 1'b1, 1'b1, "R7 0x03 kept");
        issue(1'b1, 8'h09, 5'd9, 5'd9, 1'b1, 1'b1, "R7 0x09 stored");

        // R6: expiry when a new key is exactly half the key space away
        do_reset();
        issue(1'b0, 8'h77, 5'd0, 5'd1, 1'b0, 1'b0, "R6 old reservation");
        for (int k = 2; k <= 16; k++) begin
            issue(1'b0, 8'h60, 5'd0, KEY_W'(k), 1'b0, 1'b0, "R6 churn LL");
            issue(1'b1, 8'h60, KEY_W'(k), KEY_W'(k), 1'b1, 1'b1, "R6 churn SC");
        end
        issue(1'b0, 8'h77, 5'd0, 5'd1,  1'b0, 1'b0, "R6 alive at distance 15");
        issue(1'b0, 8'h61, 5'd0, 5'd17, 1'b0, 1'b0, "R6 key 17 issued");
        issue(1'b0, 8'h77, 5'd0, 5'd18, 1'b0, 1'b0, "R6 expired gets new key");
        issue(1'b1, 8'h77, 5'd1, 5'd1,  1'b0, 1'b0, "R6 old key fails");
        issue(1'b1, 8'h77, 5'd18, 5'd18, 1'b1, 1'b1, "R6 new key wins");

        // R8: single-cycle strobe
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8 strobe one cycle", int'(rsp_valid), 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule